// File: doc/BRIEF.md
# Array Steering Vector Generator

This block turns a single arrival-direction term into a full set of complex steering weights for a ten-element uniform linear array with half-wavelength spacing. Each element sits at a fixed signed position measured from the array centre. The block multiplies that position by the direction term to get the element's phase. A pipelined CORDIC rotator then turns each phase into a cosine, the real part of the weight, and a sine, the imaginary part. All ten elements are processed in parallel, and a new direction term can be accepted on every clock cycle.

The path from input to output has a fixed length, so a neighbouring datapath that consumes the weights can balance its own delay against a known constant. The direction term is an angle rate expressed in half-turns (units of pi radians) per position unit. An element whose product runs past plus or minus one half-turn therefore wraps naturally onto the circle. The result is correct for any input value, with no range limit placed on the caller.

Top module: `steer_vec_gen`

## Requirements
- R1: A direction term sampled with `dirValid` high at clock edge n produces weights with `wtValid` high in the cycle after edge n+35. That is a fixed latency of 36 cycles, and `wtValid` is never high without a matching accepted input.
- R2: Inputs accepted on consecutive cycles come out on consecutive cycles with no bubble. Every accepted input yields exactly one output cycle.
- R3: Element k (0..9) has position (2k-9)*0.75 units, held as a signed 8-bit value with 4 fraction bits: -108, -84, -60, -36, -12, 12, 36, 60, 84 and 108. Its phase in half-turns is that position times `dirIn`, where `dirIn` is signed 16-bit with 15 fraction bits.
- R4: The phase keeps 19 fraction bits and wraps modulo two half-turns into the range [-1, 1). A product outside that range gives the same weight as its wrapped value.
- R5: Element k's weight sits at bits [16k+15:16k] of `wtRe` and `wtIm`, as signed 16-bit values with 14 fraction bits. `wtIm` equals sin(pi*phase) within 3 LSB.
- R6: `wtRe` equals cos(pi*phase) within 3 LSB in all four quadrants, including phases beyond plus or minus one quarter-turn. A fold stage handles these before the rotation iterations and leaves a residual inside plus or minus one quarter-turn.
- R7: While `wtValid` is low, `wtRe` and `wtIm` hold the last weights produced.
- R8: A synchronous active-high `rst` clears all pipeline valid bits and sets both weight buses to zero. An input presented in the same cycle as reset is dropped.
- R9: Elements k and 9-k are complex conjugates: equal real parts, and imaginary parts that sum to zero, both within 4 LSB.
- R10: The squared magnitude of each output weight is 1.0 within 2^-10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dirIn | input | 16 | Direction term, half-turns per position unit, signed with 15 fraction bits |
| dirValid | input | 1 | Marks `dirIn` as a new sample this cycle |
| wtValid | output | 1 | New weight set on the weight buses |
| wtRe | output | 160 | Ten packed real parts (cosine), element k at bits [16k+15:16k] |
| wtIm | output | 160 | Ten packed imaginary parts (sine), same packing |

## Verification
Two functions can fall in the same cycle. One is an output emerging while a fresh direction term is accepted, which happens whenever the pipeline is full. The other is a reset landing in the same cycle as a valid input. The first is provoked by a back-to-back sweep over the whole direction range. That sweep is judged by exact 36-cycle latency on every item and by matching input and output counts. The second is provoked by raising reset together with a valid input in the middle of traffic. The bench then expects zero weights, no output for the dropped or in-flight items, and correct results for the traffic that follows.

// File: rtl/steer_pkg.sv
package steer_pkg;

  // Strobes from the control pipeline to the datapath.
  typedef struct packed {
    logic inTake;    // capture the direction term
    logic foldLive;  // a real sample sits in the quadrant-fold register
    logic outLoad;   // load the output weight registers this edge
  } steerStrobe_t;

  localparam real PI_R = 3.14159265358979323846;

  // Element position, in units of the position LSB, measured from the array centre.
  function automatic int elemPos(input int k, input int nElem, input int halfStep);
    return (2 * k - (nElem - 1)) * halfStep;
  endfunction

  // Rotation angle of CORDIC step i, in half-turns scaled by 2^frac.
  function automatic int atanStep(input int i, input int frac);
    real a;
    a = $atan(2.0 ** (-i)) / PI_R * (2.0 ** frac);
    return $rtoi(a + 0.5);
  endfunction

  // Start-vector length that cancels the CORDIC growth over iters steps.
  function automatic int cordicGain(input int iters, input int frac);
    real g;
    g = 1.0;
    for (int i = 0; i < iters; i++) begin
      g = g / $sqrt(1.0 + 2.0 ** (-2 * i));
    end
    return $rtoi(g * (2.0 ** frac) + 0.5);
  endfunction

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl #(
  parameter int LATENCY    = 36,
  parameter int FOLD_STAGE = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    validIn,
  output steer_pkg::steerStrobe_t strobe,
  output logic                    validOut
);
  localparam int CNT_W = $clog2(LATENCY + 2);

  logic [LATENCY-1:0] validPipe;
  logic [CNT_W-1:0]   inFlight;

  // One valid bit per pipeline register; bit i is set after the (i+1)-th edge.
  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[LATENCY-2:0], validIn};
  end

  assign validOut = validPipe[LATENCY-1];

  always_comb begin
    strobe.inTake   = validIn;
    strobe.foldLive = validPipe[FOLD_STAGE];
    strobe.outLoad  = validPipe[LATENCY-2];
  end

  // Occupancy count of samples between input and output.
  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else if (validIn && !validOut) inFlight <= inFlight + 1'b1;
    else if (!validIn && validOut) inFlight <= inFlight - 1'b1;
  end

  AST_FLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst) inFlight <= CNT_W'(LATENCY)); // R2
  AST_NO_ORPHAN_OUT: assert property (@(posedge clk) disable iff (rst) validOut |-> (inFlight != '0)); // R1
  AST_RESET_CLEARS_VALID: assert property (@(posedge clk) rst |=> (!validOut && inFlight == '0)); // R8

endmodule

// File: rtl/steer_cordic.sv
module steer_cordic #(
  parameter int ANG_W    = 20,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 14,
  parameter int GUARD    = 4,
  parameter int ITERS    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    foldLive,
  input  logic signed [ANG_W-1:0] phaseIn,
  output logic signed [OUT_W-1:0] cosOut,
  output logic signed [OUT_W-1:0] sinOut
);
  localparam int XY_FRAC = OUT_FRAC + GUARD;
  localparam int XY_W    = OUT_W + GUARD;
  localparam int ANG_FRAC = ANG_W - 1;
  localparam logic signed [XY_W-1:0]  K_START = XY_W'(steer_pkg::cordicGain(ITERS, XY_FRAC));
  localparam logic signed [ANG_W-1:0] QUARTER = ANG_W'(1) <<< (ANG_W - 2);
  localparam logic signed [XY_W-1:0]  RND     = XY_W'(1) <<< (GUARD - 1);

  function automatic logic [ITERS*ANG_W-1:0] buildAtan();
    logic [ITERS*ANG_W-1:0] t;
    t = '0;
    for (int i = 0; i < ITERS; i++) begin
      t[i*ANG_W +: ANG_W] = ANG_W'(steer_pkg::atanStep(i, ANG_FRAC));
    end
    return t;
  endfunction

  localparam logic [ITERS*ANG_W-1:0] ATAN_PACK = buildAtan();

  logic signed [XY_W-1:0]  xs [ITERS+1];
  logic signed [XY_W-1:0]  ys [ITERS+1];
  logic signed [ANG_W-1:0] zs [ITERS+1];

  always_ff @(posedge clk) begin
    // Quadrant fold: move phases beyond a quarter-turn by exactly a quarter-turn.
    unique case (phaseIn[ANG_W-1 -: 2])
      2'b01: begin
        xs[0] <= '0;
        ys[0] <= K_START;
        zs[0] <= phaseIn - QUARTER;
      end
      2'b10: begin
        xs[0] <= '0;
        ys[0] <= -K_START;
        zs[0] <= phaseIn + QUARTER;
      end
      default: begin
        xs[0] <= K_START;
        ys[0] <= '0;
        zs[0] <= phaseIn;
      end
    endcase
    // Rotation iterations, one register per step.
    for (int i = 0; i < ITERS; i++) begin
      if (!zs[i][ANG_W-1]) begin
        xs[i+1] <= xs[i] - (ys[i] >>> i);
        ys[i+1] <= ys[i] + (xs[i] >>> i);
        zs[i+1] <= zs[i] - $signed(ATAN_PACK[i*ANG_W +: ANG_W]);
      end else begin
        xs[i+1] <= xs[i] + (ys[i] >>> i);
        ys[i+1] <= ys[i] - (xs[i] >>> i);
        zs[i+1] <= zs[i] + $signed(ATAN_PACK[i*ANG_W +: ANG_W]);
      end
    end
  end

  // Round the guard bits away.
  assign cosOut = OUT_W'((xs[ITERS] + RND) >>> GUARD);
  assign sinOut = OUT_W'((ys[ITERS] + RND) >>> GUARD);

  AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (rst) foldLive |-> (zs[0][ANG_W-1] == zs[0][ANG_W-2])); // R6

endmodule

// File: rtl/steer_datapath.sv
module steer_datapath #(
  parameter int N_ELEM        = 10,
  parameter int DIR_W         = 16,
  parameter int DIR_FRAC      = 15,
  parameter int POS_W         = 8,
  parameter int POS_FRAC      = 4,
  parameter int POS_HALF_STEP = 12,
  parameter int OUT_W         = 16,
  parameter int OUT_FRAC      = 14,
  parameter int GUARD         = 4,
  parameter int ITERS         = 16,
  parameter int PAD           = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  steer_pkg::steerStrobe_t  strobe,
  input  logic signed [DIR_W-1:0]  dirIn,
  output logic [N_ELEM*OUT_W-1:0]  wtRe,
  output logic [N_ELEM*OUT_W-1:0]  wtIm
);
  localparam int ANG_FRAC = POS_FRAC + DIR_FRAC;
  localparam int ANG_W    = ANG_FRAC + 1;
  localparam longint MAG_ONE = longint'(1) << (2 * OUT_FRAC);
  localparam longint MAG_TOL = longint'(1) << (2 * OUT_FRAC - 10);

  // Input capture followed by the balancing delay line.
  logic signed [DIR_W-1:0] dirStage [PAD+1];

  always_ff @(posedge clk) begin
    if (strobe.inTake) dirStage[0] <= dirIn;
  end

  for (genvar p = 1; p <= PAD; p++) begin : g_pad
    always_ff @(posedge clk) dirStage[p] <= dirStage[p-1];
  end

  for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
    localparam logic signed [POS_W-1:0] POS_K = POS_W'(steer_pkg::elemPos(k, N_ELEM, POS_HALF_STEP));

    logic signed [ANG_W-1:0] phaseQ;
    logic signed [OUT_W-1:0] cosR, sinR, reQ, imQ;
    logic signed [2*OUT_W:0] magSq;

    // Only the low ANG_W bits survive: that truncation is the phase wrap.
    always_ff @(posedge clk) phaseQ <= ANG_W'(POS_K) * ANG_W'(dirStage[PAD]);

    steer_cordic #(
      .ANG_W(ANG_W), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .GUARD(GUARD), .ITERS(ITERS)
    ) cordic_i (
      .clk(clk), .rst(rst), .foldLive(strobe.foldLive),
      .phaseIn(phaseQ), .cosOut(cosR), .sinOut(sinR)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        reQ <= '0;
        imQ <= '0;
      end else if (strobe.outLoad) begin
        reQ <= cosR;
        imQ <= sinR;
      end
    end

    assign wtRe[k*OUT_W +: OUT_W] = reQ;
    assign wtIm[k*OUT_W +: OUT_W] = imQ;

    assign magSq = reQ * reQ + imQ * imQ;

    AST_UNIT_MAG: assert property (@(posedge clk) disable iff (rst) $past(strobe.outLoad) |-> (magSq > MAG_ONE - MAG_TOL && magSq < MAG_ONE + MAG_TOL)); // R10
  end

  for (genvar m = 0; m < N_ELEM / 2; m++) begin : g_mirror
    logic signed [OUT_W:0] reDiff, imSum;
    assign reDiff = $signed(wtRe[m*OUT_W +: OUT_W]) - $signed(wtRe[(N_ELEM-1-m)*OUT_W +: OUT_W]);
    assign imSum  = $signed(wtIm[m*OUT_W +: OUT_W]) + $signed(wtIm[(N_ELEM-1-m)*OUT_W +: OUT_W]);

    AST_MIRROR_CONJ: assert property (@(posedge clk) disable iff (rst) $past(strobe.outLoad) |-> (reDiff >= -4 && reDiff <= 4 && imSum >= -4 && imSum <= 4)); // R9
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !strobe.outLoad |=> ($stable(wtRe) && $stable(wtIm))); // R7

endmodule

// File: rtl/steer_vec_gen.sv
module steer_vec_gen #(
  parameter int N_ELEM        = 10,
  parameter int DIR_W         = 16,
  parameter int DIR_FRAC      = 15,
  parameter int POS_W         = 8,
  parameter int POS_FRAC      = 4,
  parameter int POS_HALF_STEP = 12,
  parameter int OUT_W         = 16,
  parameter int OUT_FRAC      = 14,
  parameter int GUARD         = 4,
  parameter int ITERS         = 16,
  parameter int LATENCY       = 36
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DIR_W-1:0]        dirIn,
  input  logic                    dirValid,
  output logic                    wtValid,
  output logic [N_ELEM*OUT_W-1:0] wtRe,
  output logic [N_ELEM*OUT_W-1:0] wtIm
);
  // Core registers: capture, multiply, fold, ITERS rotations, output.
  localparam int CORE_STAGES = ITERS + 4;
  localparam int PAD         = LATENCY - CORE_STAGES;
  localparam int FOLD_STAGE  = PAD + 2;

  if (PAD < 0) begin : g_bad_latency
    $error("LATENCY is shorter than the core pipeline");
  end

  steer_pkg::steerStrobe_t strobe;

  steer_ctrl #(
    .LATENCY(LATENCY), .FOLD_STAGE(FOLD_STAGE)
  ) ctrl_i (
    .clk(clk), .rst(rst), .validIn(dirValid), .strobe(strobe), .validOut(wtValid)
  );

  steer_datapath #(
    .N_ELEM(N_ELEM), .DIR_W(DIR_W), .DIR_FRAC(DIR_FRAC), .POS_W(POS_W),
    .POS_FRAC(POS_FRAC), .POS_HALF_STEP(POS_HALF_STEP), .OUT_W(OUT_W),
    .OUT_FRAC(OUT_FRAC), .GUARD(GUARD), .ITERS(ITERS), .PAD(PAD)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .dirIn($signed(dirIn)),
    .wtRe(wtRe), .wtIm(wtIm)
  );

endmodule

// File: tb/steer_vec_gen_tb_top.sv
module steer_vec_gen_tb_top;
  localparam real PI = 3.14159265358979323846;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  dirIn = '0;
  logic         dirValid = 1'b0;
  logic         wtValid;
  logic [159:0] wtRe, wtIm;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int accCnt = 0;
  int outCnt = 0;
  bit done = 1'b0;
  bit expectZero = 1'b0;
  bit haveLast = 1'b0;
  logic [159:0] lastRe, lastIm;
  logic [15:0] dirQ [$];
  int cycQ [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  steer_vec_gen dut_i (
    .clk(clk), .rst(rst), .dirIn(dirIn), .dirValid(dirValid),
    .wtValid(wtValid), .wtRe(wtRe), .wtIm(wtIm)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wrapPhase(input int k, input int d);
    longint p;
    int ph;
    p  = longint'((2 * k - 9) * 12) * longint'(d);
    ph = int'(p & 64'hFFFFF);
    if (ph >= (1 << 19)) ph -= (1 << 20);
    return ph;
  endfunction

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic checkWeights(input logic [15:0] d);
    for (int k = 0; k < 10; k++) begin
      int ph, re, im, eRe, eIm;
      longint full, mag;
      string tag;
      ph   = wrapPhase(k, int'($signed(d)));
      full = longint'((2 * k - 9) * 12) * longint'($signed(d));
      re   = int'($signed(wtRe[k*16 +: 16]));
      im   = int'($signed(wtIm[k*16 +: 16]));
      eRe  = rnd($cos(PI * ph / 524288.0) * 16384.0);
      eIm  = rnd($sin(PI * ph / 524288.0) * 16384.0);
      if (ph >= (1 << 18) || ph < -(1 << 18)) tag = "R6";
      else if (full != longint'(ph)) tag = "R4";
      else tag = "R3";
      check(re - eRe <= 3 && eRe - re <= 3, tag, $sformatf("cos elem %0d dir %0d", k, $signed(d)), re, eRe);
      check(im - eIm <= 3 && eIm - im <= 3, "R5", $sformatf("sin elem %0d dir %0d", k, $signed(d)), im, eIm);
      mag = longint'(re) * re + longint'(im) * im;
      check(mag > (1 << 28) - (1 << 18) && mag < (1 << 28) + (1 << 18), "R10",
            $sformatf("magnitude elem %0d", k), mag, 1 << 28);
      if (k < 5) begin
        int mRe, mIm;
        mRe = int'($signed(wtRe[(9-k)*16 +: 16]));
        mIm = int'($signed(wtIm[(9-k)*16 +: 16]));
        check(re - mRe <= 4 && mRe - re <= 4 && im + mIm <= 4 && im + mIm >= -4, "R9",
              $sformatf("conjugate pair %0d/%0d", k, 9 - k), mIm, -im);
      end
    end
  endtask

  // Monitor: samples on the falling edge, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (expectZero) begin
        check(!wtValid, "R8", "valid after reset", wtValid, 0);
        check(wtRe == '0 && wtIm == '0, "R8", "weights after reset",
              longint'(wtRe[15:0]) | longint'(wtIm[15:0]), 0);
        lastRe = wtRe;
        lastIm = wtIm;
        haveLast = 1'b1;
        expectZero = 1'b0;
      end else if (wtValid) begin
        if (dirQ.size() == 0) begin
          check(1'b0, "R1", "output with no accepted input", 1, 0);
        end else begin
          logic [15:0] d;
          int c0;
          d  = dirQ.pop_front();
          c0 = cycQ.pop_front();
          check(cyc - c0 == 36, "R1", "latency", cyc - c0, 36);
          checkWeights(d);
          outCnt++;
        end
        lastRe = wtRe;
        lastIm = wtIm;
        haveLast = 1'b1;
      end else if (haveLast) begin
        check(wtRe == lastRe && wtIm == lastIm, "R7", "hold while idle",
              longint'($signed(wtRe[15:0])), longint'($signed(lastRe[15:0])));
      end
      if (rst) begin
        accCnt -= dirQ.size();
        dirQ.delete();
        cycQ.delete();
        expectZero = 1'b1;
      end else if (dirValid) begin
        dirQ.push_back(dirIn);
        cycQ.push_back(cyc);
        accCnt++;
      end
    end
  end

  task automatic send(input int d);
    @(posedge clk);
    #1;
    dirIn = 16'(d);
    dirValid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      dirValid = 1'b0;
    end
  endtask

  task automatic pulseReset();
    @(posedge clk);
    #1;
    rst = 1'b1;
    dirValid = 1'b1;
    dirIn = 16'h1234;
    @(posedge clk);
    #1;
    rst = 1'b0;
    dirValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    idle(2);
    // R2: back-to-back sweep over the whole direction range.
    for (int d = -32768; d < 32768; d += 257) send(d);
    idle(5);
    // Irregular gaps between samples; R7 holds are checked in the gaps.
    for (int i = 0; i < 40; i++) begin
      send(i * 1637 - 32000);
      idle(i % 3);
    end
    // Boundary values: zero, extremes, smallest steps, near-quadrant points.
    send(0); send(-32768); send(32767); send(1); send(-1);
    send(21845); send(-21845); send(10923); send(-10923); send(16384);
    idle(3);
    // R8: reset lands together with a valid input while items are in flight.
    send(5000); send(-7000);
    pulseReset();
    for (int i = 0; i < 20; i++) send(i * 3001 - 30000);
    idle(50);
    check(outCnt == accCnt && dirQ.size() == 0, "R2", "outputs equal accepted inputs", outCnt, accCnt);
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", outCnt, accCnt);
      finishRun();
    end
  end

endmodule